// File: doc/BRIEF.md
# Four-Register Summation Combiner Keystream Generator

This block produces a pseudo-random keystream, one bit per enabled clock, for XOR with payload data. Four Fibonacci shift registers of lengths 25, 31, 33 and 39 are stepped together. Their top bits feed a small nonlinear combiner that keeps two 2-bit memory words. The keystream bit is the XOR of the four register bits and the low bit of the combiner's current word.

A 132-bit seed is accepted through a ready/valid handshake. The seed is first mixed for 200 steps. The last 128 bits produced during mixing then replace the register contents, while the combiner memory is kept. The generator then discards 39 further steps, so 239 output bits are thrown away in total. After that, every cycle with the run enable high yields one valid keystream bit. Deriving the seed from keys or addresses is left to the surrounding logic.

The sequencer has five states. IDLE is the state after reset. An accepted seed moves IDLE to MIX, where the datapath steps 200 times. The end of the count moves MIX to RESEED, where the registers are reloaded for one cycle. RESEED moves to SETTLE, where the datapath steps 39 times. The end of that count moves SETTLE to RUN. An accepted seed in RUN moves RUN back to MIX.

Top module: `sck_keystream_gen`

## Requirements
- R1: After reset the block is idle: `seed_ready` is 1, `busy` is 0 and `ks_valid` is 0.
- R2: A seed is taken at a rising edge where `seed_valid` and `seed_ready` are both 1. Seed bits [24:0], [55:25], [88:56] and [127:89] load registers A (length 25), B (31), C (33) and D (39). Bits [129:128] load the combiner current word c, and bits [131:130] load the previous word p.
- R3: Each step shifts every register one place toward its MSB, and the feedback bit enters bit 0. The output bit of each register is its MSB. For a register of length L with taps (a,b,e), the feedback is q[L-1]^q[a-1]^q[b-1]^q[e-1]. The taps are A (20,12,8), B (24,16,12), C (28,24,4) and D (36,28,4).
- R4: Each step, y is the count of ones among the four output bits and s = floor((y + c)/2). The new c is s ^ c ^ T(p), where T({h,l}) = {l, h^l}. The new p is the old c.
- R5: The keystream bit equals the XOR of the four register output bits and c[0], taken before the step.
- R6: The 200 mixing steps are followed by one reseed cycle. Register contents are rebuilt with bit k of the 128-bit vector equal to mixing output number 72+k (counting from 0), using the R2 bit layout. Both combiner words are unchanged across the reseed.
- R7: After the 200 mixing steps and the reseed cycle, 39 further steps are discarded. `busy` is high for exactly 240 cycles after an accepted seed.
- R8: `ks_valid` is 1 only when RUN is reached, `run_en` is 1 and no seed is offered. The generator steps only in such cycles, so a low `run_en` freezes the keystream position.
- R9: While `busy` is 1, `seed_ready` is 0 and any offered seed is ignored.
- R10: A seed offered in RUN takes precedence over stepping. In that cycle `ks_valid` is 0, and the whole initialisation restarts.
- R11: An all-zero seed yields an all-zero keystream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_valid | input | 1 | Seed offered |
| seed_ready | output | 1 | Seed can be accepted |
| seed | input | 132 | Register contents and combiner words |
| run_en | input | 1 | Step and emit one keystream bit |
| busy | output | 1 | Initialisation in progress |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | `ks_bit` is a keystream bit this cycle |

## Verification
The reseed step is the hardest part to observe. Its effect reaches the ports only after 239 silent steps, and a single wrong bit in the 128-bit capture window changes every later output bit. The stimulus therefore compares long runs against a bench model for several seeds. One seed sets only the combiner words, so that the memory path alone must carry the stream through the reseed. An extra seed is driven in the middle of the busy window to show that it is ignored.

// File: rtl/sck_pkg.sv
package sck_pkg;

    localparam int NUM_REG = 4;
    localparam int REG_LEN  [NUM_REG] = '{25, 31, 33, 39};
    localparam int TAP_HI   [NUM_REG] = '{20, 24, 28, 36};
    localparam int TAP_MID  [NUM_REG] = '{12, 16, 24, 28};
    localparam int TAP_LO   [NUM_REG] = '{8, 12, 4, 4};
    localparam int COMB_BITS = 4;

    // Bit position of register idx inside the packed register vector
    function automatic int reg_offset(input int idx);
        int sum;
        sum = 0;
        for (int k = 0; k < idx; k++) begin
            sum += REG_LEN[k];
        end
        return sum;
    endfunction

    localparam int LFSR_BITS = reg_offset(NUM_REG);
    localparam int SEED_BITS = LFSR_BITS + COMB_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIX,
        ST_RESEED,
        ST_SETTLE,
        ST_RUN
    } seq_state_t;

    // Linear map applied to the older combiner word
    function automatic logic [1:0] older_map(input logic [1:0] v);
        return {v[0], v[1] ^ v[0]};
    endfunction

endpackage

// File: rtl/sck_lfsr.sv
module sck_lfsr #(
    parameter int LEN = 25,
    parameter int TA  = 20,
    parameter int TB  = 12,
    parameter int TC  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [LEN-1:0] load_val,
    input  logic           step_en,
    output logic           out_bit
);

    logic [LEN-1:0] q;
    logic           fb;

    assign out_bit = q[LEN-1];

    always_comb begin
        fb = q[LEN-1] ^ q[TA-1] ^ q[TB-1] ^ q[TC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= load_val;
        end else if (step_en) begin
            q <= {q[LEN-2:0], fb};
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> q == $past(load_val));

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> q[LEN-1:1] == $past(q[LEN-2:0]));

    p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && q != '0) |=> q != '0);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(q));

endmodule

// File: rtl/sck_combiner.sv
module sck_combiner
    import sck_pkg::*;
#(
    parameter int NREG = NUM_REG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [COMB_BITS-1:0] load_state,
    input  logic                 step_en,
    input  logic [NREG-1:0]      reg_bits,
    output logic                 ks_bit
);

    localparam int CW = $clog2(NREG + 1) + 1;

    logic [1:0]    c_now;
    logic [1:0]    c_old;
    logic [CW-1:0] ones;
    logic [CW-1:0] total;
    logic [1:0]    s_next;
    logic [1:0]    c_next;

    always_comb begin
        ones = '0;
        for (int k = 0; k < NREG; k++) begin
            ones = ones + CW'(reg_bits[k]);
        end
        total  = ones + CW'(c_now);
        s_next = total[2:1];
        c_next = s_next ^ c_now ^ older_map(c_old);
    end

    assign ks_bit = (^reg_bits) ^ c_now[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_now <= 2'b00;
            c_old <= 2'b00;
        end else if (load_en) begin
            c_now <= load_state[1:0];
            c_old <= load_state[3:2];
        end else if (step_en) begin
            c_old <= c_now;
            c_now <= c_next;
        end
    end

    p_age_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> c_old == $past(c_now));

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(c_now) && $stable(c_old));

    p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && reg_bits == '0 && c_now == 2'b00 && c_old == 2'b00)
        |=> c_now == 2'b00);

endmodule

// File: rtl/sck_sequencer.sv
module sck_sequencer
    import sck_pkg::*;
#(
    parameter int MIX_STEPS    = 200,
    parameter int SETTLE_STEPS = 39
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_valid,
    input  logic run_en,
    output logic seed_ready,
    output logic busy,
    output logic ld_seed,
    output logic ld_reseed,
    output logic step_en,
    output logic capture_en,
    output logic ks_valid
);

    localparam int MAX_STEPS = (MIX_STEPS > SETTLE_STEPS) ? MIX_STEPS : SETTLE_STEPS;
    localparam int CNT_W     = $clog2(MAX_STEPS + 1);

    seq_state_t       state;
    seq_state_t       state_nx;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             last_mix;
    logic             last_settle;

    assign accept      = seed_valid && seed_ready;
    assign last_mix    = (cnt == CNT_W'(MIX_STEPS - 1));
    assign last_settle = (cnt == CNT_W'(SETTLE_STEPS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (seed_valid) state_nx = ST_MIX;
            ST_MIX:    if (last_mix) state_nx = ST_RESEED;
            ST_RESEED: state_nx = ST_SETTLE;
            ST_SETTLE: if (last_settle) state_nx = ST_RUN;
            ST_RUN:    if (seed_valid) state_nx = ST_MIX;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= '0;
        end else if (state == ST_MIX) begin
            cnt <= last_mix ? '0 : cnt + 1'b1;
        end else if (state == ST_SETTLE) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    always_comb begin
        seed_ready = 1'b0;
        busy       = 1'b0;
        ld_seed    = 1'b0;
        ld_reseed  = 1'b0;
        step_en    = 1'b0;
        capture_en = 1'b0;
        ks_valid   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                seed_ready = 1'b1;
                ld_seed    = seed_valid;
            end
            ST_MIX: begin
                busy       = 1'b1;
                step_en    = 1'b1;
                capture_en = 1'b1;
            end
            ST_RESEED: begin
                busy      = 1'b1;
                ld_reseed = 1'b1;
            end
            ST_SETTLE: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
            ST_RUN: begin
                seed_ready = 1'b1;
                ld_seed    = seed_valid;
                step_en    = run_en && !seed_valid;
                ks_valid   = run_en && !seed_valid;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_MIX) && busy);

    p_mix_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MIX && last_mix) |=> state == ST_RESEED);

    p_settle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> cnt < CNT_W'(SETTLE_STEPS));

    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> !busy && run_en);

    p_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !seed_ready);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && seed_valid) |-> !ks_valid);

endmodule

// File: rtl/sck_keystream_gen.sv
module sck_keystream_gen
    import sck_pkg::*;
#(
    parameter int MIX_STEPS    = 200,
    parameter int SETTLE_STEPS = 39
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seed_valid,
    output logic                 seed_ready,
    input  logic [SEED_BITS-1:0] seed,
    input  logic                 run_en,
    output logic                 busy,
    output logic                 ks_bit,
    output logic                 ks_valid
);

    logic                 ld_seed;
    logic                 ld_reseed;
    logic                 step_en;
    logic                 capture_en;
    logic                 comb_z;
    logic [NUM_REG-1:0]   reg_bits;
    logic [LFSR_BITS-1:0] capture_q;
    logic [LFSR_BITS-1:0] reg_src;
    logic                 reg_load;

    sck_sequencer #(
        .MIX_STEPS   (MIX_STEPS),
        .SETTLE_STEPS(SETTLE_STEPS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_valid(seed_valid),
        .run_en    (run_en),
        .seed_ready(seed_ready),
        .busy      (busy),
        .ld_seed   (ld_seed),
        .ld_reseed (ld_reseed),
        .step_en   (step_en),
        .capture_en(capture_en),
        .ks_valid  (ks_valid)
    );

    assign reg_load = ld_seed | ld_reseed;
    assign reg_src  = ld_reseed ? capture_q : seed[LFSR_BITS-1:0];

    for (genvar gi = 0; gi < NUM_REG; gi++) begin : g_reg
        localparam int OFF = reg_offset(gi);
        localparam int LEN = REG_LEN[gi];
        sck_lfsr #(
            .LEN(LEN),
            .TA (TAP_HI[gi]),
            .TB (TAP_MID[gi]),
            .TC (TAP_LO[gi])
        ) u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (reg_load),
            .load_val(reg_src[OFF +: LEN]),
            .step_en (step_en),
            .out_bit (reg_bits[gi])
        );
    end

    sck_combiner #(
        .NREG(NUM_REG)
    ) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (ld_seed),
        .load_state(seed[SEED_BITS-1:LFSR_BITS]),
        .step_en   (step_en),
        .reg_bits  (reg_bits),
        .ks_bit    (comb_z)
    );

    // Newest mixing bit enters at the top; after the pass bit k holds output 72+k
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            capture_q <= '0;
        end else if (capture_en) begin
            capture_q <= {comb_z, capture_q[LFSR_BITS-1:1]};
        end
    end

    assign ks_bit = comb_z;

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> capture_q[LFSR_BITS-1] == $past(comb_z));

    p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(capture_q));

endmodule

// File: tb/sck_keystream_gen_test.sv
`timescale 1ns/1ps
module sck_keystream_gen_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed_valid = 1'b0;
    logic         seed_ready;
    logic [131:0] seed = '0;
    logic         run_en = 1'b0;
    logic         busy;
    logic         ks_bit;
    logic         ks_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sck_keystream_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_valid(seed_valid),
        .seed_ready(seed_ready),
        .seed      (seed),
        .run_en    (run_en),
        .busy      (busy),
        .ks_bit    (ks_bit),
        .ks_valid  (ks_valid)
    );

    // Bench model of the requirements
    int          lens [4] = '{25, 31, 33, 39};
    int          tpa  [4] = '{20, 24, 28, 36};
    int          tpb  [4] = '{12, 16, 24, 28};
    int          tpc  [4] = '{8, 12, 4, 4};
    logic [38:0] m_q  [4];
    logic [1:0]  m_c;
    logic [1:0]  m_p;

    function automatic logic m_bit(input int i);
        return m_q[i][lens[i]-1];
    endfunction

    function automatic logic m_z();
        return m_bit(0) ^ m_bit(1) ^ m_bit(2) ^ m_bit(3) ^ m_c[0];
    endfunction

    task automatic m_step();
        int y;
        int s;
        logic [1:0] tp;
        logic [1:0] cn;
        y = int'(m_bit(0)) + int'(m_bit(1)) + int'(m_bit(2)) + int'(m_bit(3));
        s = (y + int'(m_c)) / 2;
        tp = {m_p[0], m_p[1] ^ m_p[0]};
        cn = 2'(s) ^ m_c ^ tp;
        m_p = m_c;
        m_c = cn;
        for (int i = 0; i < 4; i++) begin
            logic fb;
            logic [38:0] mask;
            fb = m_q[i][lens[i]-1] ^ m_q[i][tpa[i]-1] ^ m_q[i][tpb[i]-1] ^ m_q[i][tpc[i]-1];
            mask = (39'd1 << lens[i]) - 39'd1;
            m_q[i] = ((m_q[i] << 1) | 39'(fb)) & mask;
        end
    endtask

    task automatic m_fill(input logic [127:0] v);
        int off;
        off = 0;
        for (int i = 0; i < 4; i++) begin
            logic [38:0] mask;
            mask = (39'd1 << lens[i]) - 39'd1;
            m_q[i] = 39'(v >> off) & mask;
            off += lens[i];
        end
    endtask

    task automatic m_prepare(input logic [131:0] v);
        logic [127:0] cap;
        cap = '0;
        m_fill(v[127:0]);
        m_c = v[129:128];
        m_p = v[131:130];
        for (int k = 0; k < 200; k++) begin
            if (k >= 72) cap[k-72] = m_z();
            m_step();
        end
        m_fill(cap);
        for (int k = 0; k < 39; k++) m_step();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer a seed and follow the busy window (R2, R7, R8, R9, R10)
    task automatic do_load(input logic [131:0] v, input bit intrude, input bit run_hot);
        int n;
        bit leak;
        m_prepare(v);
        @(negedge clk);
        run_en = run_hot;
        seed = v;
        seed_valid = 1'b1;
        #1;
        chk("R10 no valid while seed offered", ks_valid, 0);
        chk("R2 ready when offered", seed_ready, 1);
        @(negedge clk);
        seed_valid = 1'b0;
        run_en = 1'b1;
        #1;
        chk("R9 ready low while busy", seed_ready, 0);
        n = 0;
        leak = 0;
        while (busy && n < 1000) begin
            if (ks_valid) leak = 1;
            if (seed_ready) leak = 1;
            if (intrude && n == 50) begin
                seed = ~v;
                seed_valid = 1'b1;
            end
            if (intrude && n == 56) seed_valid = 1'b0;
            n++;
            @(negedge clk);
            #1;
        end
        seed_valid = 1'b0;
        chk("R7 busy length", n, 240);
        chk("R8 no valid or ready during busy", leak, 0);
    endtask

    // Called at negedge+1 with run_en high; leaves run_en low
    task automatic stream(input int count, input string req);
        int errs;
        errs = 0;
        for (int k = 0; k < count; k++) begin
            if (ks_valid !== 1'b1 || ks_bit !== m_z()) begin
                if (errs == 0)
                    $display("FAIL %s: bit %0d actual=%b/%b expected=1/%b",
                             req, k, ks_valid, ks_bit, m_z());
                errs++;
            end
            m_step();
            @(negedge clk);
            #1;
        end
        run_en = 1'b0;
        total++;
        if (errs != 0) bad++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R1 ready after reset", seed_ready, 1);
        chk("R1 busy after reset", busy, 0);
        chk("R1 valid after reset", ks_valid, 0);
    endtask

    task automatic t_gaps();
        for (int k = 0; k < 60; k++) begin
            run_en = (k % 3) != 0;
            #1;
            chk("R8 valid follows run_en", ks_valid, run_en);
            if (run_en) begin
                chk("R8 stream across gaps", ks_bit, m_z());
                m_step();
            end
            @(negedge clk);
        end
        run_en = 1'b0;
        #1;
    endtask

    task automatic t_zero();
        int ones;
        do_load('0, 0, 0);
        ones = 0;
        for (int k = 0; k < 100; k++) begin
            if (ks_bit) ones++;
            @(negedge clk);
            #1;
        end
        run_en = 1'b0;
        chk("R11 zero seed gives zero stream", ones, 0);
    endtask

    localparam logic [131:0] SEED_A = 132'h9_0123456789abcdef_fedcba9876543210;
    localparam logic [131:0] SEED_B = 132'h6_5a5a1234c3c3beef_0f1e2d3c4b5a6978;
    localparam logic [131:0] SEED_C = 132'h9_0000000000000000_0000000000000000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        do_load(SEED_A, 0, 0);
        stream(300, "R3 R4 R5 R6 seed A stream");
        t_gaps();
        do_load(SEED_B, 0, 0);
        stream(200, "R3 R4 R5 R6 seed B stream");
        do_load(SEED_A, 1, 0);
        stream(150, "R9 stream after ignored seed");
        do_load(SEED_C, 0, 0);
        stream(150, "R2 R4 R6 combiner-only seed");
        run_en = 1'b1;
        do_load(SEED_B, 0, 1);
        stream(100, "R10 restart from RUN");
        t_zero();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule